// File: doc/BRIEF.md
# Timer Capture/Compare PWM Channel

This block is one channel of a 16-bit timer. The counter and its overflow pulse live outside the channel and arrive as inputs. The channel then works in one of two ways. In capture mode it samples the counter when a chosen edge appears on the input pin. In compare mode it drives the pin when the counter matches a stored value and when the counter overflows. Compare mode can produce edge-aligned PWM. The PWM can be unbuffered, where a new compare value acts at once. It can also be buffered, where a new compare value waits for the next overflow.

Software reaches the channel through an 8-bit register port. One address holds the control byte, and two further addresses hold the high and low bytes of the 16-bit channel value. Because the value is moved one byte at a time, the channel guards it. A half-read captured value is not overwritten until the low byte has been read. A half-written compare value does not fire until its low byte has been written. A maximum-duty override forces the PWM to a constant active level. The override starts and stops only on overflow boundaries.

Top module: `tmr_chan`

## Requirements
- R1: After reset, `flag_o`, `pin_o` and `pin_oe` are 0 and the control register reads 0x00. This clears the toggle-on-overflow bit.
- R2: Control register layout at address 0: bit 7 is the flag (read only), bit 6 reads 0, bits 5:4 are the mode, bits 3:2 are the edge/level select, bit 1 is toggle-on-overflow and bit 0 is max-duty. Address 1 is the value high byte, address 2 is the value low byte, and address 3 reads 0.
- R3: Mode 00 is capture. The pin passes through a two-flop synchronizer. Edge select 01 captures on rising edges, 10 on falling edges and 11 on both. A capture stores `cnt_i` into the channel value and sets the flag.
- R4: In capture mode, a read of address 1 blocks captures until address 2 is read. Edges in that window are lost.
- R5: Any nonzero mode is compare. When `cnt_i` equals the compare value, the flag is set and the pin acts according to the edge/level select: 01 toggles the pin, 10 clears it and 11 sets it.
- R6: In compare mode, a write to address 1 blocks matches until address 2 is written.
- R7: With toggle-on-overflow set in compare mode, each `ovf_i` pulse drives the pin as follows: select 10 sets it, select 11 clears it and select 01 toggles it. In capture mode the bit has no effect on the pin.
- R8: With toggle-on-overflow set, an overflow and a match in the same cycle give the overflow action.
- R9: With both toggle-on-overflow and max-duty set, the pin is held at its active level, which is 1 for select 10 and 0 for select 11. The hold starts at the first overflow after max-duty is set. It lasts through matches until the first overflow after max-duty is cleared.
- R10: Edge/level select 00 deasserts `pin_oe`, and `pin_o` no longer changes.
- R11: The flag is cleared only when a read of address 0 sees it set and a later write to address 0 has bit 7 = 0. A write without that prior read leaves the flag set.
- R12: Modes 10 and 11 are buffered. A written compare value takes effect only at the next overflow. Mode 01 compares against the written value directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Shared free-running counter value |
| ovf_i | input | 1 | One-cycle counter overflow pulse |
| pin_i | input | 1 | Channel pin input level |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; read side effects occur on the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| flag_o | output | 1 | Channel event flag |
| pin_o | output | 1 | Channel pin output level |
| pin_oe | output | 1 | Channel pin output enable |

## Verification
The bench targets the byte interlocks directly. It places an input edge between the high and low reads, and a counter match between the high and low writes. A design without the interlocks would overwrite the half-read capture or toggle the pin on a half-written value. The bench also presents an overflow and a match in the same cycle, where a wrong priority ends the cycle at the compare level instead of the overflow level. It sets and clears max-duty in the middle of a period. A design that applied the bit at once would break the period in which the bit changes. The flag-clear test writes 0 without a preceding read, which a design that lacked the read-then-write order would accept.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    localparam int BYTE_W = 8;
    localparam int VAL_W  = 2 * BYTE_W;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_VHI  = 2'd1,
        A_VLO  = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    localparam logic [1:0] SEL_OFF  = 2'b00;
    localparam logic [1:0] SEL_TOG  = 2'b01;
    localparam logic [1:0] SEL_CLR  = 2'b10;
    localparam logic [1:0] SEL_SET  = 2'b11;

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] sel;
        logic       tov;
        logic       maxd;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic              flag;
        logic              arm;
        logic              cap_lock;
        logic              cmp_lock;
        logic              force_on;
        logic              pin;
        logic [VAL_W-1:0]  val;
        logic [VAL_W-1:0]  act;
    } chan_t;

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] edge_sel,
    output logic       edge_hit
);

    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] sync_d;
    logic              prev_q;

    assign sync_d[0] = pin_i;
    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_chain
            assign sync_d[i] = sync_q[i-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= sync_q[STAGES-1];
        end
    end

    logic rise_w, fall_w;
    assign rise_w   = sync_q[STAGES-1] & ~prev_q;
    assign fall_w   = ~sync_q[STAGES-1] & prev_q;
    assign edge_hit = (edge_sel[0] & rise_w) | (edge_sel[1] & fall_w);

endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] direct_val,
    input  logic [W-1:0] shadow_val,
    input  logic         use_shadow,
    input  logic         enable,
    output logic         match
);

    logic [W-1:0] ref_w;
    assign ref_w = use_shadow ? shadow_val : direct_val;
    assign match = enable && (cnt == ref_w);

endmodule

// File: rtl/tmr_pin_ctl.sv
module tmr_pin_ctl
    import tmr_chan_pkg::*;
(
    input  logic       cmp_mode,
    input  logic [1:0] sel,
    input  logic       tov,
    input  logic       maxd,
    input  logic       ovf,
    input  logic       match,
    input  logic       force_q,
    input  logic       pin_q,
    output logic       pin_d
);

    logic active_lvl;
    logic ovf_act;

    assign active_lvl = (sel != SEL_SET);
    assign ovf_act    = ovf && tov;

    always_comb begin
        pin_d = pin_q;
        if (cmp_mode && sel != SEL_OFF) begin
            if (ovf_act) begin
                if (maxd || sel != SEL_TOG) pin_d = active_lvl;
                else                        pin_d = ~pin_q;
            end else if (force_q) begin
                pin_d = active_lvl;
            end else if (match) begin
                unique case (sel)
                    SEL_TOG: pin_d = ~pin_q;
                    SEL_CLR: pin_d = 1'b0;
                    SEL_SET: pin_d = 1'b1;
                    default: pin_d = pin_q;
                endcase
            end
        end
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VAL_W-1:0]  cnt_i,
    input  logic              ovf_i,
    input  logic              pin_i,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              flag_o,
    output logic              pin_o,
    output logic              pin_oe
);

    chan_t state_q, state_d;

    logic cap_mode, cmp_mode, buffered;
    logic edge_hit, match, cap_evt, pin_next;
    logic wr_ctrl, wr_hi, wr_lo, rd_ctrl, rd_hi, rd_lo;

    logic [1:0]       mode_w, sel_w;
    logic             cap_lock_w, cmp_lock_w;
    logic [VAL_W-1:0] val_w;

    assign mode_w     = state_q.ctrl.mode;
    assign sel_w      = state_q.ctrl.sel;
    assign cap_lock_w = state_q.cap_lock;
    assign cmp_lock_w = state_q.cmp_lock;
    assign val_w      = state_q.val;

    assign cap_mode = (state_q.ctrl.mode == 2'b00);
    assign cmp_mode = !cap_mode;
    assign buffered = state_q.ctrl.mode[1];

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_hi   = wr_en && (addr == A_VHI);
    assign wr_lo   = wr_en && (addr == A_VLO);
    assign rd_ctrl = rd_en && (addr == A_CTRL);
    assign rd_hi   = rd_en && (addr == A_VHI);
    assign rd_lo   = rd_en && (addr == A_VLO);

    tmr_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .edge_sel (cap_mode ? state_q.ctrl.sel : SEL_OFF),
        .edge_hit (edge_hit)
    );

    tmr_cmp_unit #(.W(VAL_W)) u_cmp (
        .cnt        (cnt_i),
        .direct_val (state_q.val),
        .shadow_val (state_q.act),
        .use_shadow (buffered),
        .enable     (cmp_mode && !state_q.cmp_lock),
        .match      (match)
    );

    tmr_pin_ctl u_pin (
        .cmp_mode (cmp_mode),
        .sel      (state_q.ctrl.sel),
        .tov      (state_q.ctrl.tov),
        .maxd     (state_q.ctrl.maxd),
        .ovf      (ovf_i),
        .match    (match),
        .force_q  (state_q.force_on),
        .pin_q    (state_q.pin),
        .pin_d    (pin_next)
    );

    assign cap_evt = edge_hit && !state_q.cap_lock;

    always_comb begin
        state_d = state_q;

        if (wr_ctrl) begin
            state_d.ctrl.mode = wdata[5:4];
            state_d.ctrl.sel  = wdata[3:2];
            state_d.ctrl.tov  = wdata[1];
            state_d.ctrl.maxd = wdata[0];
        end

        // value bytes; a capture overrides a same-cycle write
        if (wr_hi) state_d.val[VAL_W-1:BYTE_W] = wdata;
        if (wr_lo) state_d.val[BYTE_W-1:0]     = wdata;
        if (cap_evt) state_d.val = cnt_i;

        // byte interlocks
        if (rd_hi && cap_mode) state_d.cap_lock = 1'b1;
        if (rd_lo)             state_d.cap_lock = 1'b0;
        if (wr_hi && cmp_mode) state_d.cmp_lock = 1'b1;
        if (wr_lo)             state_d.cmp_lock = 1'b0;

        // buffered compare value moves over on overflow
        if (ovf_i && buffered && !state_q.cmp_lock) state_d.act = state_q.val;

        // force window changes only on overflow
        if (ovf_i)
            state_d.force_on = cmp_mode && state_q.ctrl.tov && state_q.ctrl.maxd;
        else
            state_d.force_on = state_q.force_on && cmp_mode;

        // flag clear sequence: read while set, then write 0
        if (wr_ctrl)                    state_d.arm = 1'b0;
        else if (rd_ctrl && state_q.flag) state_d.arm = 1'b1;
        if (wr_ctrl && state_q.arm && !wdata[7]) state_d.flag = 1'b0;
        if (cap_evt || match)           state_d.flag = 1'b1;

        state_d.pin = pin_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ctrl     <= '0;
            state_q.flag     <= 1'b0;
            state_q.arm      <= 1'b0;
            state_q.cap_lock <= 1'b0;
            state_q.cmp_lock <= 1'b0;
            state_q.force_on <= 1'b0;
            state_q.pin      <= 1'b0;
            state_q.act      <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {state_q.flag, 1'b0, state_q.ctrl.mode, state_q.ctrl.sel,
                              state_q.ctrl.tov, state_q.ctrl.maxd};
            A_VHI:   rdata = state_q.val[VAL_W-1:BYTE_W];
            A_VLO:   rdata = state_q.val[BYTE_W-1:0];
            default: rdata = '0;
        endcase
    end

    assign flag_o = state_q.flag;
    assign pin_o  = state_q.pin;
    assign pin_oe = cmp_mode && (state_q.ctrl.sel != SEL_OFF);

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
    import tmr_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              flag_o,
    input  logic              pin_o,
    input  logic [1:0]        mode,
    input  logic [1:0]        sel,
    input  logic              cap_lock,
    input  logic              cmp_lock,
    input  logic [VAL_W-1:0]  val
);

    // R4: a half-read capture is not overwritten
    a_r4_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_lock && !wr_en) |=> $stable(val));

    // R6: no match may raise the flag while the compare value is half written
    a_r6_cmp_block: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && cmp_lock && !flag_o) |=> !flag_o);

    // R10: a disconnected channel leaves the pin level alone
    a_r10_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_OFF) |=> $stable(pin_o));

    // R7: capture mode never moves the pin
    a_r7_cap_no_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> $stable(pin_o));

    // R11: the flag falls only after a control write with bit 7 low
    a_r11_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(wr_en && addr == A_CTRL && !wdata[7]));

endmodule

bind tmr_chan tmr_chan_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .flag_o   (flag_o),
    .pin_o    (pin_o),
    .mode     (mode_w),
    .sel      (sel_w),
    .cap_lock (cap_lock_w),
    .cmp_lock (cmp_lock_w),
    .val      (val_w)
);

// File: tb/tmr_chan_test.sv
module tmr_chan_test;

    localparam logic [15:0] IDLE = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = IDLE;
    logic        ovf_i = 1'b0;
    logic        pin_i = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic        flag_o, pin_o, pin_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tmr_chan uut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .ovf_i(ovf_i), .pin_i(pin_i),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .flag_o(flag_o), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_i = 1'b0; cnt_i = IDLE; ovf_i = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic hit(input logic [15:0] v);
        @(negedge clk); cnt_i = v;
        @(negedge clk); cnt_i = IDLE;
    endtask

    task automatic ovf();
        @(negedge clk); ovf_i = 1'b1;
        @(negedge clk); ovf_i = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk); pin_i = v;
        repeat (4) @(negedge clk);
    endtask

    // R1, R2
    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        chk("R1 flag", {15'd0, flag_o}, 16'd0);
        chk("R1 pin", {14'd0, pin_o, pin_oe}, 16'd0);
        rd(2'd0, d);
        chk("R1 ctrl", {8'd0, d}, 16'h0000);
        wr(2'd0, 8'hFF);
        rd(2'd0, d);
        chk("R2 ctrl layout", {8'd0, d}, 16'h003F);
        rd(2'd3, d);
        chk("R2 addr3", {8'd0, d}, 16'h0000);
        wr(2'd1, 8'hA5); wr(2'd2, 8'h5A);
        rd(2'd1, d); chk("R2 hi byte", {8'd0, d}, 16'h00A5);
        rd(2'd2, d); chk("R2 lo byte", {8'd0, d}, 16'h005A);
        do_reset();
        rd(2'd0, d);
        chk("R1 tov cleared", {8'd0, d}, 16'h0000);
    endtask

    // R3
    task automatic t_capture();
        logic [7:0] hi, lo;
        for (int s = 1; s < 4; s++) begin
            for (int fall = 0; fall < 2; fall++) begin
                logic exp_cap;
                exp_cap = fall ? s[1] : s[0];
                do_reset();
                if (fall) set_pin(1'b1);
                wr(2'd0, {4'h0, s[1:0], 2'b00});
                cnt_i = 16'h1200 + 16'(s * 16 + fall);
                set_pin(fall ? 1'b0 : 1'b1);
                chk($sformatf("R3 flag sel%0d fall%0d", s, fall), {15'd0, flag_o}, {15'd0, exp_cap});
                if (exp_cap) begin
                    rd(2'd1, hi); rd(2'd2, lo);
                    chk("R3 captured value", {hi, lo}, 16'h1200 + 16'(s * 16 + fall));
                end
                cnt_i = IDLE;
            end
        end
    endtask

    // R4
    task automatic t_cap_lock();
        logic [7:0] hi, lo;
        do_reset();
        wr(2'd0, 8'h04);
        cnt_i = 16'h1111; set_pin(1'b1);
        rd(2'd1, hi);
        chk("R4 first hi", {8'd0, hi}, 16'h0011);
        cnt_i = 16'h2222; set_pin(1'b0); set_pin(1'b1);
        rd(2'd2, lo);
        chk("R4 edge blocked lo", {8'd0, lo}, 16'h0011);
        rd(2'd1, hi); rd(2'd2, lo);
        chk("R4 value kept", {hi, lo}, 16'h1111);
        cnt_i = 16'h3333; set_pin(1'b0); set_pin(1'b1);
        rd(2'd1, hi); rd(2'd2, lo);
        chk("R4 capture after unlock", {hi, lo}, 16'h3333);
    endtask

    // R5
    task automatic t_compare();
        logic [1:0] e1, e2;
        for (int s = 1; s < 4; s++) begin
            do_reset();
            wr(2'd1, 8'h01); wr(2'd2, 8'h00);
            wr(2'd0, {4'h1, s[1:0], 2'b00});
            chk("R5 oe on", {15'd0, pin_oe}, 16'd1);
            hit(16'h0100);
            e1 = (s == 2) ? 2'b00 : 2'b01;
            chk($sformatf("R5 first match sel%0d", s), {14'd0, flag_o, pin_o}, {14'd0, 1'b1, e1[0]});
            hit(16'h0100);
            e2 = (s == 3) ? 2'b01 : 2'b00;
            chk($sformatf("R5 second match sel%0d", s), {15'd0, pin_o}, {14'd0, e2});
        end
    endtask

    // R6
    task automatic t_cmp_lock();
        do_reset();
        wr(2'd1, 8'h01); wr(2'd2, 8'h00);
        wr(2'd0, 8'h14);
        wr(2'd1, 8'h02);
        hit(16'h0200);
        chk("R6 match blocked", {14'd0, flag_o, pin_o}, 16'd0);
        wr(2'd2, 8'h00);
        hit(16'h0200);
        chk("R6 match after unlock", {14'd0, flag_o, pin_o}, 16'h0003);
    endtask

    // R7
    task automatic t_tov();
        do_reset();
        wr(2'd1, 8'h01); wr(2'd2, 8'h00);
        wr(2'd0, 8'h1A);
        ovf(); chk("R7 sel10 ovf sets", {15'd0, pin_o}, 16'd1);
        hit(16'h0100); chk("R7 sel10 match clears", {15'd0, pin_o}, 16'd0);
        ovf(); chk("R7 sel10 ovf sets again", {15'd0, pin_o}, 16'd1);
        wr(2'd0, 8'h1E);
        ovf(); chk("R7 sel11 ovf clears", {15'd0, pin_o}, 16'd0);
        wr(2'd0, 8'h16);
        ovf(); chk("R7 sel01 ovf toggles", {15'd0, pin_o}, 16'd1);
        ovf(); chk("R7 sel01 ovf toggles back", {15'd0, pin_o}, 16'd0);
        do_reset();
        wr(2'd0, 8'h06);
        ovf(); chk("R7 capture mode ignores tov", {14'd0, pin_o, pin_oe}, 16'd0);
    endtask

    // R8
    task automatic t_prec();
        do_reset();
        wr(2'd1, 8'h01); wr(2'd2, 8'h00);
        wr(2'd0, 8'h1A);
        ovf();
        @(negedge clk); cnt_i = 16'h0100; ovf_i = 1'b1;
        @(negedge clk); cnt_i = IDLE; ovf_i = 1'b0;
        chk("R8 sel10 overflow wins", {15'd0, pin_o}, 16'd1);
        wr(2'd0, 8'h1E);
        ovf();
        @(negedge clk); cnt_i = 16'h0100; ovf_i = 1'b1;
        @(negedge clk); cnt_i = IDLE; ovf_i = 1'b0;
        chk("R8 sel11 overflow wins", {15'd0, pin_o}, 16'd0);
    endtask

    // R9
    task automatic t_max();
        do_reset();
        wr(2'd1, 8'h01); wr(2'd2, 8'h00);
        wr(2'd0, 8'h1A);
        ovf(); hit(16'h0100);
        chk("R9 normal period", {15'd0, pin_o}, 16'd0);
        ovf();
        wr(2'd0, 8'h1B);
        hit(16'h0100);
        chk("R9 not forced in setting period", {15'd0, pin_o}, 16'd0);
        ovf(); hit(16'h0100);
        chk("R9 forced after overflow", {15'd0, pin_o}, 16'd1);
        ovf(); hit(16'h0100);
        chk("R9 still forced", {15'd0, pin_o}, 16'd1);
        wr(2'd0, 8'h1A);
        hit(16'h0100);
        chk("R9 forced through clearing period", {15'd0, pin_o}, 16'd1);
        ovf();
        chk("R9 overflow level at release", {15'd0, pin_o}, 16'd1);
        hit(16'h0100);
        chk("R9 released", {15'd0, pin_o}, 16'd0);
    endtask

    // R10
    task automatic t_disc();
        do_reset();
        wr(2'd1, 8'h01); wr(2'd2, 8'h00);
        wr(2'd0, 8'h1A);
        ovf();
        wr(2'd0, 8'h12);
        chk("R10 oe off", {15'd0, pin_oe}, 16'd0);
        hit(16'h0100); ovf();
        chk("R10 pin frozen", {15'd0, pin_o}, 16'd1);
    endtask

    // R11
    task automatic t_flag();
        logic [7:0] d;
        do_reset();
        wr(2'd0, 8'h04);
        set_pin(1'b1);
        chk("R11 flag set", {15'd0, flag_o}, 16'd1);
        wr(2'd0, 8'h04);
        chk("R11 write without read", {15'd0, flag_o}, 16'd1);
        rd(2'd0, d);
        chk("R11 read shows flag", {15'd0, d[7]}, 16'd1);
        wr(2'd0, 8'h04);
        chk("R11 cleared", {15'd0, flag_o}, 16'd0);
    endtask

    // R12
    task automatic t_buf();
        do_reset();
        wr(2'd1, 8'h01); wr(2'd2, 8'h00);
        wr(2'd0, 8'h24);
        ovf();
        chk("R12 ovf without tov", {15'd0, pin_o}, 16'd0);
        hit(16'h0100);
        chk("R12 buffered match", {15'd0, pin_o}, 16'd1);
        wr(2'd1, 8'h03); wr(2'd2, 8'h00);
        hit(16'h0300);
        chk("R12 new value waits", {15'd0, pin_o}, 16'd1);
        hit(16'h0100);
        chk("R12 old value active", {15'd0, pin_o}, 16'd0);
        ovf(); hit(16'h0300);
        chk("R12 new value after overflow", {15'd0, pin_o}, 16'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_capture();
        t_cap_lock();
        t_compare();
        t_cmp_lock();
        t_tov();
        t_prec();
        t_max();
        t_disc();
        t_flag();
        t_buf();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule